// File: doc/BRIEF.md
# Audio Stripe Control Calculator

This block chooses how many serial data output lines an audio stream should be spread across. It takes the stream's channel count, sample width and sample rate, the controller's line capability and a per-line bandwidth threshold. A start strobe latches these inputs and begins a search.

The search starts at the largest line count the controller offers and halves the count at each step. At each candidate it computes the per-line bandwidth and stops at the first candidate that reaches the threshold. The chosen count is returned as a 2-bit stripe code, together with a one-cycle done pulse.

Every integer division goes through one shared restoring divider. The divider spends a fixed number of cycles on each quotient, so the total latency depends only on the sample rate and on how many candidates are tried.

Top module: `stripe_calc`

## Requirements
- R1: After reset, busy, done and stripeCode are all 0.
- R2: A start seen while idle latches every input and raises busy from the next cycle. Busy stays high until done, and done arrives within 120 cycles.
- R3: The first candidate line count is twice capLines, so capLines values 0, 1, 2 and 3 give 0, 2, 4 and 6 lines. Each later candidate is the previous count shifted right by one.
- R4: When sampleRate is above 48000, the per-line value is chanCnt × sampleBits × floor(sampleRate / 48000), divided by the line count with the remainder dropped.
- R5: When sampleRate is 48000 or less, the per-line value is chanCnt × sampleBits divided by the line count with the remainder dropped.
- R6: The search stops at the first candidate whose per-line value is greater than or equal to bwLimit. stripeCode is that line count shifted right by one.
- R7: When no candidate reaches bwLimit, or capLines is 0, the count reaches zero and stripeCode is 0.
- R8: done is high for exactly one cycle. stripeCode is valid in that cycle and holds its value until the next done.
- R9: A start that arrives while busy is ignored. The running calculation completes with its originally latched inputs, and no extra done follows.
- R10: The divider never gets a zero divisor, and each of its remainders is smaller than its divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted only while idle) |
| chanCnt | input | CH_W | Channel count |
| sampleBits | input | BITS_W | Bits per sample |
| sampleRate | input | RATE_W | Sample rate in Hz |
| capLines | input | 2 | Line capability field; the maximum line count is twice this value |
| bwLimit | input | LIM_W | Per-line bandwidth threshold |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle result strobe |
| stripeCode | output | 2 | Chosen line count shifted right by one |

## Verification
The start is accepted on the clock edge where it is seen. Busy is therefore due at the falling edge that follows, and the bench checks it there.

The stripe code has no fixed latency, because each rate division and each candidate adds one full divider pass. The bench drives inputs and samples outputs on falling edges. It polls done on every falling edge and reads stripeCode in the same half-cycle that done is seen.

At that point the bench checks three things:
- the number of cycles taken is within the R2 bound;
- done is gone one cycle later;
- the code is unchanged several cycles later.

For the ignored start, the bench watches for a second done over a window longer than a full calculation.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RATECHK, ST_SCALE, ST_PROD, ST_LINE, ST_LDIV, ST_CMP, ST_FIN
  } stripeState_t;

  typedef struct packed {
    logic latch;
    logic loadScale;
    logic setUnity;
    logic takeRatio;
    logic mulProd;
    logic loadLine;
    logic halve;
    logic finish;
  } stripeStrb_t;
endpackage

// File: rtl/stripe_div.sv
module stripe_div #(
  parameter int DIV_W = 20,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DIV_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [DIV_W-1:0] quo,
  output logic             divDone
);
  localparam int CNT_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] quoQ;
  logic [DEN_W-1:0] remQ, denQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {remQ, quoQ[DIV_W-1]};
  assign ge    = trial >= {1'b0, denQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoQ  <= '0;
      remQ  <= '0;
      denQ  <= '0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else if (load) begin
      quoQ  <= num;
      remQ  <= '0;
      denQ  <= den;
      cntQ  <= CNT_W'(DIV_W);
      doneQ <= 1'b0;
    end else if (cntQ != '0) begin
      quoQ  <= {quoQ[DIV_W-2:0], ge};
      remQ  <= ge ? DEN_W'(trial - {1'b0, denQ}) : trial[DEN_W-1:0];
      cntQ  <= cntQ - 1'b1;
      doneQ <= (cntQ == CNT_W'(1));
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign quo     = quoQ;
  assign divDone = doneQ;

  assert_nonzero_den_R10: assert property (@(posedge clk) disable iff (!rstN)
    load |-> den != '0);
  assert_rem_below_den_R10: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> remQ < denQ);
endmodule

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import stripe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rateHigh,
  input  logic        lineZero,
  input  logic        meets,
  input  logic        divDone,
  output stripeStrb_t strb,
  output logic        busy,
  output logic        done
);
  stripeState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strb.latch = 1'b1;
        stateD     = ST_RATECHK;
      end
      ST_RATECHK: if (rateHigh) begin
        strb.loadScale = 1'b1;
        stateD         = ST_SCALE;
      end else begin
        strb.setUnity = 1'b1;
        stateD        = ST_PROD;
      end
      ST_SCALE: if (divDone) begin
        strb.takeRatio = 1'b1;
        stateD         = ST_PROD;
      end
      ST_PROD: begin
        strb.mulProd = 1'b1;
        stateD       = ST_LINE;
      end
      ST_LINE: if (lineZero) begin
        strb.finish = 1'b1;
        stateD      = ST_FIN;
      end else begin
        strb.loadLine = 1'b1;
        stateD        = ST_LDIV;
      end
      ST_LDIV: if (divDone) stateD = ST_CMP;
      ST_CMP: if (meets) begin
        strb.finish = 1'b1;
        stateD      = ST_FIN;
      end else begin
        strb.halve = 1'b1;
        stateD     = ST_LINE;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = stateQ != ST_IDLE;
  assign done = stateQ == ST_FIN;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_div_sync_R10: assert property (@(posedge clk) disable iff (!rstN)
    divDone |-> (stateQ == ST_SCALE || stateQ == ST_LDIV));
endmodule

// File: rtl/stripe_dpath.sv
module stripe_dpath
  import stripe_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int BITS_W    = 6,
  parameter int RATE_W    = 20,
  parameter int LIM_W     = 16,
  parameter int BASE_RATE = 48000
) (
  input  logic              clk,
  input  logic              rstN,
  input  stripeStrb_t       strb,
  input  logic              busy,
  input  logic [CH_W-1:0]   chanCnt,
  input  logic [BITS_W-1:0] sampleBits,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [1:0]        capLines,
  input  logic [LIM_W-1:0]  bwLimit,
  output logic              rateHigh,
  output logic              lineZero,
  output logic              meets,
  output logic              divDone,
  output logic [1:0]        stripeCode
);
  localparam int DEN_W   = $clog2(BASE_RATE + 1);
  localparam int RATIO_W = RATE_W - DEN_W + 1;
  localparam int NUM_W   = CH_W + BITS_W + RATIO_W;
  localparam int DIV_W   = (NUM_W > RATE_W) ? NUM_W : RATE_W;

  logic [CH_W-1:0]    chQ;
  logic [BITS_W-1:0]  bitsQ;
  logic [RATE_W-1:0]  rateQ;
  logic [LIM_W-1:0]   limQ;
  logic [2:0]         lineQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [NUM_W-1:0]   prodQ;
  logic [1:0]         codeQ;
  logic [DIV_W-1:0]   divNum, quo;
  logic [DEN_W-1:0]   divDen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chQ    <= '0;
      bitsQ  <= '0;
      rateQ  <= '0;
      limQ   <= '0;
      lineQ  <= '0;
      ratioQ <= '0;
      prodQ  <= '0;
      codeQ  <= '0;
    end else begin
      if (strb.latch) begin
        chQ   <= chanCnt;
        bitsQ <= sampleBits;
        rateQ <= sampleRate;
        limQ  <= bwLimit;
        lineQ <= {capLines, 1'b0};
      end
      if (strb.setUnity)  ratioQ <= RATIO_W'(1);
      if (strb.takeRatio) ratioQ <= quo[RATIO_W-1:0];
      if (strb.mulProd)   prodQ  <= NUM_W'(chQ) * NUM_W'(bitsQ) * NUM_W'(ratioQ);
      if (strb.halve)     lineQ  <= lineQ >> 1;
      if (strb.finish)    codeQ  <= lineQ[2:1];
    end
  end

  assign divNum = strb.loadScale ? DIV_W'(rateQ) : DIV_W'(prodQ);
  assign divDen = strb.loadScale ? DEN_W'(BASE_RATE) : DEN_W'(lineQ);

  stripe_div #(.DIV_W(DIV_W), .DEN_W(DEN_W)) i_div (
    .clk     (clk),
    .rstN    (rstN),
    .load    (strb.loadScale | strb.loadLine),
    .num     (divNum),
    .den     (divDen),
    .quo     (quo),
    .divDone (divDone)
  );

  assign rateHigh   = rateQ > RATE_W'(BASE_RATE);
  assign lineZero   = lineQ == '0;
  assign meets      = quo >= DIV_W'(limQ);
  assign stripeCode = codeQ;

  assert_busy_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.latch) |=> ($stable(limQ) && $stable(rateQ) && $stable(chQ)));
  assert_line_nonzero_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLine |-> lineQ != '0);
  assert_halve_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.halve |-> lineQ != '0);
endmodule

// File: rtl/stripe_calc.sv
module stripe_calc
  import stripe_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int BITS_W = 6,
  parameter int RATE_W = 20,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CH_W-1:0]   chanCnt,
  input  logic [BITS_W-1:0] sampleBits,
  input  logic [RATE_W-1:0] sampleRate,
  input  logic [1:0]        capLines,
  input  logic [LIM_W-1:0]  bwLimit,
  output logic              busy,
  output logic              done,
  output logic [1:0]        stripeCode
);
  stripeStrb_t strb;
  logic rateHigh, lineZero, meets, divDone;

  stripe_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rateHigh(rateHigh), .lineZero(lineZero), .meets(meets), .divDone(divDone),
    .strb(strb), .busy(busy), .done(done)
  );

  stripe_dpath #(.CH_W(CH_W), .BITS_W(BITS_W), .RATE_W(RATE_W), .LIM_W(LIM_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .chanCnt(chanCnt), .sampleBits(sampleBits), .sampleRate(sampleRate),
    .capLines(capLines), .bwLimit(bwLimit),
    .rateHigh(rateHigh), .lineZero(lineZero), .meets(meets), .divDone(divDone),
    .stripeCode(stripeCode)
  );

  assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

// File: tb/test_stripe_calc.sv
module test_stripe_calc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  chanCnt = '0;
  logic [5:0]  sampleBits = '0;
  logic [19:0] sampleRate = '0;
  logic [1:0]  capLines = '0;
  logic [15:0] bwLimit = '0;
  logic        busy, done;
  logic [1:0]  stripeCode;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  stripe_calc i_stripe_calc (
    .clk(clk), .rstN(rstN), .start(start), .chanCnt(chanCnt), .sampleBits(sampleBits),
    .sampleRate(sampleRate), .capLines(capLines), .bwLimit(bwLimit),
    .busy(busy), .done(done), .stripeCode(stripeCode)
  );

  function automatic int refCode(int ch, int bits, int rate, int cap, int lim);
    int lines = cap * 2;
    while (lines > 0) begin
      int v = (rate > 48000) ? (ch * bits * (rate / 48000)) / lines : (ch * bits) / lines;
      if (v >= lim) break;
      lines = lines >> 1;
    end
    return lines >> 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runOp(string req, int ch, int bits, int rate, int cap, int lim);
    int n = 0;
    int exp = refCode(ch, bits, rate, cap, lim);
    @(negedge clk);
    chanCnt = 5'(ch); sampleBits = 6'(bits); sampleRate = 20'(rate);
    capLines = 2'(cap); bwLimit = 16'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    check("R2 latency bound", int'(n <= 120), 1);
    check(req, int'(stripeCode), exp);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R8 code held", int'(stripeCode), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
    check("R1 code reset", int'(stripeCode), 0);
    rstN = 1'b1;

    runOp("R5 low rate 4 lines", 8, 16, 48000, 2, 32);   // 128/4=32 -> code 2
    runOp("R6 fallback to 2 lines", 8, 16, 44100, 2, 40); // 32<40, 64 -> code 1
    runOp("R6 fallback to 1 line", 2, 16, 48000, 3, 30); // 6 lines:5, 3:10, 1:32
    runOp("R3 six lines", 2, 16, 48000, 3, 5);           // 32/6=5 -> code 3
    runOp("R3 three lines", 2, 16, 48000, 3, 10);        // 32/3=10 -> code 1
    runOp("R4 high rate scale", 8, 16, 192000, 2, 128);  // 512/4=128 -> code 2
    runOp("R4 just above 48k", 8, 16, 48001, 2, 33);     // ratio 1: 32 fails, 64 ok
    runOp("R7 none meet", 2, 8, 48000, 3, 100);
    runOp("R7 zero capability", 31, 32, 192000, 0, 0);
    runOp("R6 limit zero", 1, 1, 8000, 3, 0);            // 1/6=0 >=0 -> code 3

    // R9: start while busy is ignored
    begin
      int n = 0;
      int extra = 0;
      int exp = refCode(8, 16, 48000, 2, 32);
      @(negedge clk);
      chanCnt = 5'd8; sampleBits = 6'd16; sampleRate = 20'd48000;
      capLines = 2'd2; bwLimit = 16'd32; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chanCnt = 5'd1; bwLimit = 16'd9000; capLines = 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 300) begin
        @(negedge clk);
        n++;
      end
      check("R9 first inputs kept", int'(stripeCode), exp);
      repeat (200) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R9 no extra done", extra, 0);
    end

    for (int i = 0; i < 40; i++) begin
      int ch   = 1 + int'($urandom % 31);
      int bits = 8 + int'($urandom % 25);
      int rate = (i % 2 == 0) ? int'($urandom % 48001) : 48001 + int'($urandom % 900000);
      int cap  = int'($urandom % 4);
      int lim  = int'($urandom % 1200);
      runOp((rate > 48000) ? "R4 R6 random" : "R5 R6 random", ch, bits, rate, cap, lim);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule